// File: doc/BRIEF.md
# Selective-Execution Writeback Mask Unit

This unit sits at the writeback stage of a 256-bit wide-register datapath. It decides which subfields of a freshly computed result are committed to the destination register. For each writeback it receives the new result, the current destination contents and per-lane condition flags. A 3-bit mode field from the instruction picks where the per-element enables come from: every element, a software-loaded mask register, one of four condition flags, or the mask combined with the equality flag. Elements that are not selected keep their old value. The unit returns the merged word and a 32-bit lane write-enable vector one cycle after the write strobe.

Elements may be 8, 16 or 32 bits wide. Enables are kept at the granularity of 8-bit lanes. A wider element takes its enable from the bit of its lowest lane and applies it to all of its lanes. The mask register is loaded through its own write port, and a load becomes visible on the following cycle.

Top module: `selx_commit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `out_lane_we` is all zeros, `out_data` is zero and the mask register holds zero, so a mode 001 writeback with no mask load enables no lane.
- R2: `out_valid`, `out_lane_we` and `out_data` are updated on the clock edge that samples `wb_valid` high, which is one cycle after the strobe. In a cycle that follows no strobe, `out_valid` is 0 and `out_lane_we` is all zeros.
- R3: In every result, each 8-bit lane whose enable is set carries the result lane. Each lane whose enable is clear carries the old destination lane.
- R4: Mode 000 enables every lane. Mode 111 enables no lane, so the output equals the old destination.
- R5: Mode 001 uses the mask register, with bit i belonging to lane i (bits 7..0 of the word are lane 0).
- R6: Modes 010, 011, 100 and 101 use the per-lane EQ, GT, LT and OV flag vectors respectively, with bit i belonging to lane i.
- R7: Mode 110 uses the bitwise AND of the mask register and the EQ flags.
- R8: Element size 00 is 8-bit, 01 is 16-bit, and 10 or 11 is 32-bit. For wider elements, every lane of an element takes the selection bit of the element's lowest lane.
- R9: A mask load takes effect on the next cycle. A writeback in the same cycle as a load uses the previous mask value.
- R10: With the mask set to enable only the upper 16 lanes and a result whose halves are swapped, the lower half of the output equals the old destination and the upper half equals the lower half of the unswapped source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_we | input | 1 | Load strobe for the mask register |
| mask_wdata | input | 32 | New mask value, one bit per 8-bit lane |
| wb_valid | input | 1 | Writeback strobe |
| wb_mode | input | 3 | Selection mode: 000 all, 001 mask, 010 EQ, 011 GT, 100 LT, 101 OV, 110 mask AND EQ, 111 none |
| wb_esize | input | 2 | Element size: 00 8-bit, 01 16-bit, 10/11 32-bit |
| wb_result | input | 256 | New result word |
| wb_old | input | 256 | Current destination word |
| cc_eq | input | 32 | Per-lane equal flags |
| cc_gt | input | 32 | Per-lane greater-than flags |
| cc_lt | input | 32 | Per-lane less-than flags |
| cc_ov | input | 32 | Per-lane overflow flags |
| out_valid | output | 1 | Merged result valid |
| out_data | output | 256 | Merged word to commit |
| out_lane_we | output | 32 | Per-lane write enables of the committed word |

## Verification
If the mask register held a wrong value, the error would show only on mask-mode writebacks, as wrong bits in `out_lane_we` exactly one cycle after the strobe. It would stay invisible until such a writeback occurs, which is why the bench loads a mask and writes back in the same cycle. If the element-size widening were broken, lane enables inside one 16-bit or 32-bit element would disagree. This shows on the very next output, because the flag patterns give adjacent lanes opposite bits. If the merge picked the wrong side, the old and new data would be swapped in the affected lanes of that same output. The lane-distinct data patterns tie each failure to its lane.

// File: rtl/selx_pkg.sv
// Shared encodings for the selective-execution writeback unit.
// Assumes: the mode field is 3 bits and the element size field is 2 bits.
package selx_pkg;
    typedef enum logic [2:0] {
        MODE_ALL     = 3'b000,
        MODE_MASK    = 3'b001,
        MODE_EQ      = 3'b010,
        MODE_GT      = 3'b011,
        MODE_LT      = 3'b100,
        MODE_OV      = 3'b101,
        MODE_MASK_EQ = 3'b110,
        MODE_NONE    = 3'b111
    } sel_mode_e;

    typedef enum logic [1:0] {
        ESZ_8   = 2'b00,
        ESZ_16  = 2'b01,
        ESZ_32  = 2'b10,
        ESZ_32B = 2'b11
    } elem_size_e;
endpackage

// File: rtl/selx_mask_reg.sv
// Holds the software-loaded lane mask, one bit per lane.
// Assumes: a load is visible from the cycle after mask_we; reset clears it.
module selx_mask_reg #(
    parameter int NUM_LANES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_we,
    input  logic [NUM_LANES-1:0] mask_wdata,
    output logic [NUM_LANES-1:0] mask_q
);
    // Load or clear the mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    AST_MASK_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_q == $past(mask_wdata)); // R9
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q)); // R9
endmodule

// File: rtl/selx_lane_sel.sv
// Builds per-lane enables from the instruction mode and element size.
// Assumes: wider elements take the selection bit of their lowest lane.
module selx_lane_sel
    import selx_pkg::*;
#(
    parameter int NUM_LANES = 32,
    parameter int LANE_W    = 8
) (
    input  logic [2:0]           mode,
    input  logic [1:0]           esize,
    input  logic [NUM_LANES-1:0] mask,
    input  logic [NUM_LANES-1:0] cc_eq,
    input  logic [NUM_LANES-1:0] cc_gt,
    input  logic [NUM_LANES-1:0] cc_lt,
    input  logic [NUM_LANES-1:0] cc_ov,
    output logic [NUM_LANES-1:0] lane_en
);
    localparam int L16 = 16 / LANE_W;
    localparam int L32 = 32 / LANE_W;

    logic [NUM_LANES-1:0] raw_sel;

    // Pick the source of the lane-level selection bits.
    always_comb begin
        case (sel_mode_e'(mode))
            MODE_ALL:     raw_sel = '1;
            MODE_MASK:    raw_sel = mask;
            MODE_EQ:      raw_sel = cc_eq;
            MODE_GT:      raw_sel = cc_gt;
            MODE_LT:      raw_sel = cc_lt;
            MODE_OV:      raw_sel = cc_ov;
            MODE_MASK_EQ: raw_sel = mask & cc_eq;
            default:      raw_sel = '0;
        endcase
    end

    // Spread the lowest-lane bit of each element over the element.
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int B16 = i - (i % L16);
        localparam int B32 = i - (i % L32);
        assign lane_en[i] = (esize == ESZ_8)  ? raw_sel[i]   :
                            (esize == ESZ_16) ? raw_sel[B16] : raw_sel[B32];
    end
endmodule

// File: rtl/selx_merge.sv
// Registers the merge of result and old destination under lane enables.
// Assumes: enables are final when strobe is high; output lags by one cycle.
module selx_merge #(
    parameter int NUM_LANES = 32,
    parameter int LANE_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        valid,
    input  logic [NUM_LANES-1:0]        lane_en,
    input  logic [NUM_LANES*LANE_W-1:0] result,
    input  logic [NUM_LANES*LANE_W-1:0] old,
    output logic                        out_valid,
    output logic [NUM_LANES*LANE_W-1:0] out_data,
    output logic [NUM_LANES-1:0]        out_we
);
    logic [NUM_LANES*LANE_W-1:0] merged;

    // Choose new or old contents lane by lane.
    always_comb begin
        for (int i = 0; i < NUM_LANES; i++)
            merged[i*LANE_W +: LANE_W] = lane_en[i] ? result[i*LANE_W +: LANE_W]
                                                    : old[i*LANE_W +: LANE_W];
    end

    // Register the merged word and its enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_we    <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= valid;
            out_we    <= valid ? lane_en : '0;
            if (valid) out_data <= merged;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> out_valid); // R2
    AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_we == '0); // R2
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_chk
        AST_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
            valid && !lane_en[i] |=> out_data[i*LANE_W +: LANE_W] == $past(old[i*LANE_W +: LANE_W])); // R3
        AST_TAKE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
            valid && lane_en[i] |=> out_data[i*LANE_W +: LANE_W] == $past(result[i*LANE_W +: LANE_W])); // R3
    end
endmodule

// File: rtl/selx_commit.sv
// Top of the selective-execution writeback unit: mask register, lane
// enable selection and registered merge.
// Assumes: 8-bit lanes; element size and mode encodings come from selx_pkg.
module selx_commit
    import selx_pkg::*;
#(
    parameter int LANE_W    = 8,
    parameter int NUM_LANES = 32,
    localparam int DATA_W   = LANE_W * NUM_LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_we,
    input  logic [NUM_LANES-1:0] mask_wdata,
    input  logic                 wb_valid,
    input  logic [2:0]           wb_mode,
    input  logic [1:0]           wb_esize,
    input  logic [DATA_W-1:0]    wb_result,
    input  logic [DATA_W-1:0]    wb_old,
    input  logic [NUM_LANES-1:0] cc_eq,
    input  logic [NUM_LANES-1:0] cc_gt,
    input  logic [NUM_LANES-1:0] cc_lt,
    input  logic [NUM_LANES-1:0] cc_ov,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_data,
    output logic [NUM_LANES-1:0] out_lane_we
);
    localparam int L32 = 32 / LANE_W;

    logic [NUM_LANES-1:0] mask_q;
    logic [NUM_LANES-1:0] lane_en;

    selx_mask_reg #(.NUM_LANES(NUM_LANES)) u_mask (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .mask_q(mask_q)
    );

    selx_lane_sel #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_sel (
        .mode(wb_mode), .esize(wb_esize), .mask(mask_q),
        .cc_eq(cc_eq), .cc_gt(cc_gt), .cc_lt(cc_lt), .cc_ov(cc_ov),
        .lane_en(lane_en)
    );

    selx_merge #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .valid(wb_valid), .lane_en(lane_en),
        .result(wb_result), .old(wb_old),
        .out_valid(out_valid), .out_data(out_data), .out_we(out_lane_we)
    );

    AST_MODE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && wb_mode == MODE_ALL |=> out_lane_we == '1); // R4
    AST_MODE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && wb_mode == MODE_NONE |=> out_lane_we == '0); // R4
    for (genvar g = 0; g < NUM_LANES / L32; g++) begin : g_elem
        AST_ELEM32_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
            wb_valid && wb_esize[1] |=>
            (out_lane_we[g*L32 +: L32] == '0 || out_lane_we[g*L32 +: L32] == '1)); // R8
    end
endmodule

// File: tb/selx_commit_bench.sv
// Scoreboard bench: driver pushes expected results, monitor compares outputs.
module selx_commit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mask_we = 1'b0;
    logic [31:0]  mask_wdata = '0;
    logic         wb_valid = 1'b0;
    logic [2:0]   wb_mode = '0;
    logic [1:0]   wb_esize = '0;
    logic [255:0] wb_result = '0;
    logic [255:0] wb_old = '0;
    logic [31:0]  cc_eq = '0, cc_gt = '0, cc_lt = '0, cc_ov = '0;
    logic         out_valid;
    logic [255:0] out_data;
    logic [31:0]  out_lane_we;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] bm_mask = '0;

    typedef struct {
        logic [31:0]  we;
        logic [255:0] data;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    selx_commit u_selx_commit (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .wb_valid(wb_valid), .wb_mode(wb_mode), .wb_esize(wb_esize),
        .wb_result(wb_result), .wb_old(wb_old),
        .cc_eq(cc_eq), .cc_gt(cc_gt), .cc_lt(cc_lt), .cc_ov(cc_ov),
        .out_valid(out_valid), .out_data(out_data), .out_lane_we(out_lane_we)
    );

    function automatic logic [255:0] pat(input logic [7:0] base, input logic [7:0] step);
        logic [255:0] v;
        for (int i = 0; i < 32; i++) v[i*8 +: 8] = base + step * 8'(i);
        return v;
    endfunction

    function automatic logic [31:0] exp_en(input logic [2:0] m, input logic [1:0] sz,
                                           input logic [31:0] mk, input logic [31:0] eq,
                                           input logic [31:0] gt, input logic [31:0] lt,
                                           input logic [31:0] ov);
        logic [31:0] s, e;
        case (m)
            3'd0: s = 32'hFFFF_FFFF;
            3'd1: s = mk;
            3'd2: s = eq;
            3'd3: s = gt;
            3'd4: s = lt;
            3'd5: s = ov;
            3'd6: s = mk & eq;
            default: s = 32'h0;
        endcase
        for (int i = 0; i < 32; i++) begin
            if (sz == 2'd0)      e[i] = s[i];
            else if (sz == 2'd1) e[i] = s[i & ~1];
            else                 e[i] = s[i & ~3];
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_wb(input logic [2:0] m, input logic [1:0] sz,
                            input logic [255:0] res, input logic [255:0] od,
                            input logic [31:0] eq, input logic [31:0] gt,
                            input logic [31:0] lt, input logic [31:0] ov,
                            input string tag, input bit ld, input logic [31:0] ldv);
        exp_t it;
        logic [31:0] en;
        @(negedge clk);
        wb_valid = 1'b1; wb_mode = m; wb_esize = sz; wb_result = res; wb_old = od;
        cc_eq = eq; cc_gt = gt; cc_lt = lt; cc_ov = ov;
        mask_we = ld; mask_wdata = ldv;
        en = exp_en(m, sz, bm_mask, eq, gt, lt, ov);
        it.we = en;
        for (int i = 0; i < 32; i++)
            it.data[i*8 +: 8] = en[i] ? res[i*8 +: 8] : od[i*8 +: 8];
        it.tag = tag;
        sb.push_back(it);
        if (ld) bm_mask = ldv;
    endtask

    task automatic write_mask(input logic [31:0] v);
        @(negedge clk);
        wb_valid = 1'b0; mask_we = 1'b1; mask_wdata = v;
        bm_mask = v;
    endtask

    task automatic go_idle(input int n);
        @(negedge clk);
        wb_valid = 1'b0; mask_we = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every valid output with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2 unexpected out_valid", 256'(out_lane_we), 256'h0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                check(out_lane_we == it.we, {it.tag, " lane_we"}, 256'(out_lane_we), 256'(it.we));
                check(out_data == it.data, {it.tag, " data"}, out_data, it.data);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [255:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of outputs
        check(out_valid == 1'b0 && out_lane_we == '0 && out_data == '0, "R1 reset outputs",
              out_data, 256'h0);
        // R1: mask cleared by reset, mask mode enables nothing
        drive_wb(3'd1, 2'd0, pat(8'h80, 8'd1), pat(8'h00, 8'd1), '0, '0, '0, '0,
                 "R1 mask reset", 1'b0, '0);
        // R4: all lanes and no lanes; back-to-back also checks R2 latency
        drive_wb(3'd0, 2'd0, pat(8'h10, 8'd3), pat(8'h55, 8'd5), '0, '0, '0, '0,
                 "R4 mode all", 1'b0, '0);
        drive_wb(3'd7, 2'd0, pat(8'h20, 8'd7), pat(8'h33, 8'd2), '1, '1, '1, '1,
                 "R4 mode none", 1'b0, '0);
        go_idle(2);
        // R2: no strobe gives idle outputs
        check(out_valid == 1'b0 && out_lane_we == '0, "R2 idle", 256'(out_lane_we), 256'h0);
        // R5: mask mode
        write_mask(32'h0F0F_00FF);
        drive_wb(3'd1, 2'd0, pat(8'hA0, 8'd1), pat(8'h01, 8'd2), '0, '0, '0, '0,
                 "R5 mask mode", 1'b0, '0);
        // R6: each condition flag
        drive_wb(3'd2, 2'd0, pat(8'hC0, 8'd3), pat(8'h02, 8'd1), 32'h1234_5678, 32'hFFFF_0000,
                 32'h0000_FFFF, 32'h8000_0001, "R6 EQ", 1'b0, '0);
        drive_wb(3'd3, 2'd0, pat(8'hC1, 8'd3), pat(8'h03, 8'd1), 32'h1234_5678, 32'hF0F0_1111,
                 32'h0000_FFFF, 32'h8000_0001, "R6 GT", 1'b0, '0);
        drive_wb(3'd4, 2'd0, pat(8'hC2, 8'd3), pat(8'h04, 8'd1), 32'h1234_5678, 32'hF0F0_1111,
                 32'h00A5_5A00, 32'h8000_0001, "R6 LT", 1'b0, '0);
        drive_wb(3'd5, 2'd0, pat(8'hC3, 8'd3), pat(8'h05, 8'd1), 32'h1234_5678, 32'hF0F0_1111,
                 32'h00A5_5A00, 32'h8000_0003, "R6 OV", 1'b0, '0);
        // R7: mask AND EQ
        drive_wb(3'd6, 2'd0, pat(8'hE0, 8'd5), pat(8'h06, 8'd3), 32'h3333_3333, '0, '0, '0,
                 "R7 mask and eq", 1'b0, '0);
        // R8: 16-bit and 32-bit elements use lowest lane bit
        drive_wb(3'd2, 2'd1, pat(8'h40, 8'd1), pat(8'h90, 8'd1), 32'hAAAA_5555, '0, '0, '0,
                 "R8 esize16", 1'b0, '0);
        drive_wb(3'd3, 2'd2, pat(8'h41, 8'd2), pat(8'h91, 8'd1), '0, 32'h1E1E_E1E1, '0, '0,
                 "R8 esize32", 1'b0, '0);
        drive_wb(3'd3, 2'd3, pat(8'h42, 8'd2), pat(8'h92, 8'd1), '0, 32'h0011_2233, '0, '0,
                 "R8 esize32 code11", 1'b0, '0);
        // R9: same-cycle load uses old mask, next writeback uses new one
        drive_wb(3'd1, 2'd0, pat(8'h70, 8'd1), pat(8'h07, 8'd1), '0, '0, '0, '0,
                 "R9 old mask", 1'b1, 32'hF000_000F);
        drive_wb(3'd1, 2'd0, pat(8'h71, 8'd1), pat(8'h08, 8'd1), '0, '0, '0, '0,
                 "R9 new mask", 1'b0, '0);
        go_idle(1);
        // R10: upper-half mask with half-swapped result
        a = pat(8'h11, 8'd1);
        b = pat(8'hEE, 8'd3);
        write_mask(32'hFFFF_0000);
        drive_wb(3'd1, 2'd2, {a[127:0], a[255:128]}, b, '0, '0, '0, '0,
                 "R10 half swap", 1'b0, '0);
        go_idle(2);
        check(out_data[127:0] == b[127:0] && out_data[255:128] == a[127:0],
              "R10 halves", out_data, {a[127:0], b[127:0]});
        check(sb.size() == 0, "R2 scoreboard drained", 256'(sb.size()), 256'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule